// File: doc/BRIEF.md
# Interrupt Status and Mask Unit for an Instrument-Bus Interface

This block gathers the event pulses produced by the protocol logic of a parallel instrument-bus interface controller and turns them into two sticky 8-bit status registers and one active-low interrupt request. Every event bit is captured whether or not it is enabled. Two 8-bit mask registers decide which captured events reach the interrupt line.

A host reaches the unit through a chip select, a 3-bit register select and read and write strobes. Select 000 reaches status register A on reads and mask A on writes. Select 001 reaches status register B on reads and mask B on writes. The other six selects lead nowhere in this block.

Reading a status register returns its value from before the clear and then empties it. The bits of the other register are kept. Register A carries the two summary bits in its top two positions, so one read of it tells the host which register holds an enabled event. A software clear input empties both status registers. A hardware reset empties both status registers and both masks.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse held high for one cycle sets its status bit at the next clock edge, whatever the mask bit is. Register A holds, from bit 5 down to bit 0: byte received, ready for next byte, end, serial poll active, remote/local change, my-address. Register B holds, from bit 7 down to bit 0: trigger, handshake error, unrecognised command, secondary address, device clear, my-address, service request, interface clear.
- R2: A status bit stays set until a clearing read of its register, a software clear or a hardware reset.
- R3: With chip select high, a read with select 000 returns summary A in bit 7, summary B in bit 6 and status A in bits 5..0. A read with select 001 returns status B. Any other select returns 0x00.
- R4: A read returns the value from before the clear. At the next edge it clears only the register that was read.
- R5: An event that arrives in the same cycle as a clearing read of its register wins, and its bit is set after that edge.
- R6: With chip select high, a write with select 000 loads mask A and a write with select 001 loads mask B. Writes to any other select change neither mask.
- R7: Summary A is the OR over register A of (status AND mask). Summary B is the same for register B.
- R8: irq_n is the NOR of the two summaries, so it is low while any enabled event is pending.
- R9: A hardware reset clears both status registers and both masks. After reset, reads return 0x00 and irq_n stays high even when events then arrive.
- R10: soft_clr clears both status registers at the next edge, including over an event in the same cycle. It leaves the masks unchanged.
- R11: Read and write strobes have no effect while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| host_cs | input | 1 | Chip select, active high |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; a cycle with chip select high is one clearing read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the current state |
| soft_clr | input | 1 | Software clear of both status registers |
| evt_a | input | 6 | Event pulses for status register A, bits 5..0 |
| evt_b | input | 8 | Event pulses for status register B, bits 7..0 |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions check on every cycle the following rules:
- Each event is captured after its pulse.
- A bit is not lost without a clearing read or a software clear.
- A read of B leaves B empty.
- A write of mask B loads the write data.
- A low irq_n always has a pending status bit behind it.

Only the bench's scenarios show the exact read-data layout, including the summary bits inside register A. They also show that reading one register spares the other, and that masks survive a software clear but not a reset. A last group shows that unmasked events never reach irq_n.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int REG_W  = 8;
    localparam int NREG   = 2;
    localparam int SEL_W  = 3;
    localparam int EVA_W  = REG_W - NREG;

    typedef struct packed {
        logic [NREG-1:0] mask_we;
        logic [NREG-1:0] stat_clr;
    } host_ctl_t;
endpackage

// File: rtl/irq_host_decode.sv
module irq_host_decode
    import irq_status_pkg::*;
(
    input  logic             host_cs,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    output host_ctl_t        ctl
);
    always_comb begin
        ctl = '0;
        for (int i = 0; i < NREG; i++) begin
            if (host_cs && host_sel == SEL_W'(i)) begin
                ctl.mask_we[i]  = host_wr;
                ctl.stat_clr[i] = host_rd;
            end
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         rd_clr,
    input  logic [W-1:0] evt,
    output logic [W-1:0] stat_q
);
    typedef struct packed {
        logic [W-1:0] stat;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (rd_clr) begin
            bank_d.stat = '0;
        end
        bank_d.stat = bank_d.stat | evt;
        if (soft_clr) begin
            bank_d.stat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_q = bank_q.stat;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (load) begin
            m_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mask_q = m_q.mask;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cs,
    input  logic [SEL_W-1:0] host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             soft_clr,
    input  logic [EVA_W-1:0] evt_a,
    input  logic [REG_W-1:0] evt_b,
    output logic             irq_n
);
    host_ctl_t        ctl;
    logic [REG_W-1:0] evt_vec  [NREG];
    logic [REG_W-1:0] stat_vec [NREG];
    logic [REG_W-1:0] mask_vec [NREG];
    logic [NREG-1:0]  summ;

    // flat views for the bound checker
    logic [REG_W-1:0] stat_a_w, stat_b_w, mask_b_w;

    irq_host_decode u_dec (
        .host_cs  (host_cs),
        .host_sel (host_sel),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .ctl      (ctl)
    );

    // register A leaves its top bits to the summaries, so no event drives them
    assign evt_vec[0] = {{(REG_W-EVA_W){1'b0}}, evt_a};
    assign evt_vec[1] = evt_b;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        irq_status_bank #(.W(REG_W)) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .rd_clr   (ctl.stat_clr[g]),
            .evt      (evt_vec[g]),
            .stat_q   (stat_vec[g])
        );

        irq_mask_bank #(.W(REG_W)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (ctl.mask_we[g]),
            .wdata  (host_wdata),
            .mask_q (mask_vec[g])
        );

        assign summ[g] = |(stat_vec[g] & mask_vec[g]);
    end

    assign irq_n = ~|summ;

    always_comb begin
        host_rdata = '0;
        if (host_cs) begin
            case (host_sel)
                SEL_W'(0): begin
                    host_rdata = stat_vec[0];
                    for (int i = 0; i < NREG; i++) begin
                        host_rdata[REG_W-1-i] = summ[i];
                    end
                end
                SEL_W'(1): host_rdata = stat_vec[1];
                default:   host_rdata = '0;
            endcase
        end
    end

    assign stat_a_w = stat_vec[0];
    assign stat_b_w = stat_vec[1];
    assign mask_b_w = mask_vec[1];
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_status_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_cs,
    input logic [SEL_W-1:0] host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic [REG_W-1:0] host_wdata,
    input logic             soft_clr,
    input logic [EVA_W-1:0] evt_a,
    input logic [REG_W-1:0] evt_b,
    input logic             irq_n,
    input logic [REG_W-1:0] stat_a,
    input logic [REG_W-1:0] stat_b,
    input logic [REG_W-1:0] mask_b
);
    // R1 R5
    evt_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_clr |=> ((stat_a[EVA_W-1:0] & $past(evt_a)) == $past(evt_a)));

    // R1 R5
    evt_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_clr |=> ((stat_b & $past(evt_b)) == $past(evt_b)));

    // R2
    sticky_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !(host_cs && host_rd && host_sel == 3'd0))
        |=> ((stat_a & $past(stat_a)) == $past(stat_a)));

    // R4
    rd_clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_rd && host_sel == 3'd1 && evt_b == '0) |=> (stat_b == '0));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (stat_a == '0 && stat_b == '0));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (stat_a != '0 || stat_b != '0));

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && host_sel == 3'd1) |=> (mask_b == $past(host_wdata)));

    // R11
    no_cs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs && !soft_clr) |=> ((stat_b & $past(stat_b)) == $past(stat_b)));
endmodule

bind irq_status_unit irq_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .soft_clr   (soft_clr),
    .evt_a      (evt_a),
    .evt_b      (evt_b),
    .irq_n      (irq_n),
    .stat_a     (stat_a_w),
    .stat_b     (stat_b_w),
    .mask_b     (mask_b_w)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    import irq_status_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_cs = 1'b0;
    logic [SEL_W-1:0] host_sel = '0;
    logic             host_wr = 1'b0;
    logic             host_rd = 1'b0;
    logic [REG_W-1:0] host_wdata = '0;
    logic [REG_W-1:0] host_rdata;
    logic             soft_clr = 1'b0;
    logic [EVA_W-1:0] evt_a = '0;
    logic [REG_W-1:0] evt_b = '0;
    logic             irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_status_unit dut (
        .clk, .rst_n, .host_cs, .host_sel, .host_wr, .host_rd,
        .host_wdata, .host_rdata, .soft_clr, .evt_a, .evt_b, .irq_n
    );

    // fields: evt_a, evt_b, mask A, mask B, read A, read B, irq_n
    localparam int NV = 6;
    localparam logic [48:0] VEC [NV] = '{
        {8'h20, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 1'b1},
        {8'h20, 8'h00, 8'h20, 8'h00, 8'hA0, 8'h00, 1'b0},
        {8'h00, 8'h01, 8'h00, 8'h01, 8'h40, 8'h01, 1'b0},
        {8'h0F, 8'hF0, 8'h30, 8'h0F, 8'h0F, 8'hF0, 1'b1},
        {8'h3F, 8'hFF, 8'h01, 8'h80, 8'hFF, 8'hFF, 1'b0},
        {8'h04, 8'h00, 8'hC0, 8'h00, 8'h04, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic cs, input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_cs = cs; host_sel = sel; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic cs, input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_cs = cs; host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        evt_a = a[EVA_W-1:0]; evt_b = b;
        @(negedge clk);
        evt_a = '0; evt_b = '0;
        #1;
    endtask

    task automatic sclr();
        @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        #1 check("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
        rd_reg(1'b1, 3'd0, d); check("R9 read A after reset", d, 8'h00);
        rd_reg(1'b1, 3'd1, d); check("R9 read B after reset", d, 8'h00);
        pulse(8'h3F, 8'hFF);
        check("R9 masks zero after reset", {7'b0, irq_n}, 8'h01);
        sclr();

        // table walk: R1 R3 R7 R8 R4
        for (int v = 0; v < NV; v++) begin
            sclr();
            wr_reg(1'b1, 3'd0, VEC[v][32:25]);
            wr_reg(1'b1, 3'd1, VEC[v][24:17]);
            pulse(VEC[v][48:41], VEC[v][40:33]);
            check($sformatf("R8 vec %0d irq_n", v), {7'b0, irq_n}, {7'b0, VEC[v][0]});
            rd_reg(1'b1, 3'd0, d);
            check($sformatf("R1/R3/R7 vec %0d read A", v), d, VEC[v][16:9]);
            rd_reg(1'b1, 3'd1, d);
            check($sformatf("R1/R3/R7 vec %0d read B", v), d, VEC[v][8:1]);
            rd_reg(1'b1, 3'd0, d);
            check($sformatf("R4 vec %0d read A after clear", v), d, 8'h00);
        end

        // R4: reading B spares A
        sclr();
        wr_reg(1'b1, 3'd0, 8'hFF);
        wr_reg(1'b1, 3'd1, 8'hFF);
        pulse(8'h02, 8'h10);
        rd_reg(1'b1, 3'd1, d); check("R4 read B value", d, 8'h10);
        rd_reg(1'b1, 3'd0, d); check("R4 A kept after B read", d, 8'h82);
        #1 check("R8 irq_n after both cleared", {7'b0, irq_n}, 8'h01);

        // R2: bits stay without reads
        pulse(8'h08, 8'h00);
        repeat (5) @(negedge clk);
        rd_reg(1'b1, 3'd0, d); check("R2 sticky bit", d, 8'h88);

        // R5: event during clearing read wins
        pulse(8'h20, 8'h00);
        @(negedge clk);
        host_cs = 1'b1; host_sel = 3'd0; host_rd = 1'b1; evt_a = 6'h01;
        #1 d = host_rdata;
        check("R5 pre-clear read value", d, 8'hA0);
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0; evt_a = '0;
        rd_reg(1'b1, 3'd0, d); check("R5 event survives clear", d, 8'h81);

        // R3: other selects read zero
        pulse(8'h3F, 8'hFF);
        rd_reg(1'b1, 3'd5, d); check("R3 unused select reads zero", d, 8'h00);

        // R11: read without chip select does not clear
        rd_reg(1'b0, 3'd1, d); check("R11 no-cs read data", d, 8'h00);
        rd_reg(1'b1, 3'd1, d); check("R11 B kept after no-cs read", d, 8'hFF);

        // R10: soft clear keeps masks, beats same-cycle event
        sclr();
        #1 check("R10 irq_n after soft clear", {7'b0, irq_n}, 8'h01);
        rd_reg(1'b1, 3'd0, d); check("R10 A empty", d, 8'h00);
        pulse(8'h00, 8'h04);
        check("R10 mask B kept", {7'b0, irq_n}, 8'h00);
        @(negedge clk);
        soft_clr = 1'b1; evt_b = 8'h02;
        @(negedge clk);
        soft_clr = 1'b0; evt_b = '0;
        rd_reg(1'b1, 3'd1, d); check("R10 soft clear over event", d, 8'h00);

        // R6 R11: writes elsewhere or without cs leave masks alone
        wr_reg(1'b1, 3'd0, 8'h00);
        wr_reg(1'b1, 3'd1, 8'h00);
        wr_reg(1'b1, 3'd2, 8'hFF);
        wr_reg(1'b1, 3'd7, 8'hFF);
        wr_reg(1'b0, 3'd0, 8'hFF);
        wr_reg(1'b0, 3'd1, 8'hFF);
        pulse(8'h3F, 8'hFF);
        check("R6/R11 masks unchanged", {7'b0, irq_n}, 8'h01);
        sclr();

        // R9: mid-run hardware reset
        wr_reg(1'b1, 3'd0, 8'h3F);
        pulse(8'h01, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R9 irq_n after mid reset", {7'b0, irq_n}, 8'h01);
        pulse(8'h01, 8'h00);
        check("R9 mask A cleared by reset", {7'b0, irq_n}, 8'h01);
        rd_reg(1'b1, 3'd0, d); check("R9 A holds new event only", d, 8'h01);

        done = 1'b1;
        finish_run();
    end
endmodule